// File: doc/BRIEF.md
# Slot-Timed Transmit Event Sequencer

This block plays back one programmed burst-transmit sequence for each time slot. While idle, a host loads a header and an event table through a simple write port. The header holds a start delay and the transmit-enable level to apply at the trigger. The table holds sixteen entries, and each entry is a 4-bit event code with a tick delay counted from the previous event. After the table is loaded, the host raises a configuration-valid level. From then on, every rising edge of the slot clock starts a run. During a run the block steps through the table, counting ticks, and at each entry it drives the transmit-enable pin, the power-DAC ramp strobes, the carrier-sense window or the modulator start and end strobes.

Bit stuffing makes the length of a burst vary. The modulation-end entry therefore does not count from the slot edge. It waits for the modulator to report that the last bit has left, and then counts a fixed 30 ticks plus its own programmed delay. Every entry after it is timed from that point, so the table never has to change with the message length. A tick lasts `CLKS_PER_TICK` clock cycles, which is the system clock divided down to a 24 kHz rate. One modulated bit lasts 2.5 ticks.

Top module: `slot_tx_seq`

## Requirements
- R1: A slot_clk rising edge sampled while idle with cfg_valid high raises busy_o. In the same cycle txen_o takes the header level, which is bit 0 of cfg_code in a header write.
- R2: Let the trigger be sampled on clock edge k, with header delay I and entry delay D, where T = CLKS_PER_TICK. Entry 0 takes effect at edge k+3+(I+D0)·T. Each later entry takes effect 2+D·T edges after the one before it.
- R3: Code 0011 sets txen_o high and code 1000 sets it low. Code 0100 gives a one-cycle ramp_up_o pulse, code 0111 gives a one-cycle ramp_dn_o pulse, and code 0101 gives a one-cycle mod_start_o pulse.
- R4: When cs_en is high as the entry takes effect, code 0001 sets cs_win_o and code 0010 clears it. When cs_en is low, both codes behave as dummies. cs_win_o is cleared at each trigger.
- R5: When code 0110 is reached, the sequence holds until last_bit_done is sampled high, on edge p. The entry then gives a mod_end_o pulse at edge p+1+(D+30)·T, and later entries are timed from that edge.
- R6: Code 0000 and the unlisted codes 1001 to 1111 change no output, but they still use up their delay.
- R7: A slot_clk rising edge has no effect while busy_o is high, and none while cfg_valid is low. This includes an edge sampled on the same clock edge at which the final entry takes effect.
- R8: busy_o falls on the clock edge at which entry 15 takes effect. The next slot edge after that starts a new run.
- R9: While rst is high, all outputs are low. A write with cfg_hdr=0 stores {cfg_code, cfg_dly} at index cfg_idx. A write with cfg_hdr=1 stores the header delay from cfg_dly and the header level from cfg_code[0].
- R10: A last_bit_done pulse that arrives while the sequence is not waiting at a modulation-end entry is ignored. This covers pulses while idle and pulses in the cycle the entry is being fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_hdr | input | 1 | 1 selects the header, 0 selects a table entry |
| cfg_idx | input | $clog2(N_EV) | Table entry index |
| cfg_code | input | 4 | Event code (bit 0 is the header txen level) |
| cfg_dly | input | DLY_W | Delay in ticks |
| cfg_valid | input | 1 | Table is valid; triggers are accepted only while this is high |
| slot_clk | input | 1 | Slot clock; its rising edge starts a run |
| cs_en | input | 1 | Enables the carrier-sense window events |
| last_bit_done | input | 1 | Pulse from the modulator: last bit has left |
| busy_o | output | 1 | A sequence is running |
| txen_o | output | 1 | Registered transmit-enable pin |
| cs_win_o | output | 1 | Carrier-sense window open |
| ramp_up_o | output | 1 | One-cycle DAC ramp-up strobe |
| ramp_dn_o | output | 1 | One-cycle DAC ramp-down strobe |
| mod_start_o | output | 1 | One-cycle modulation start strobe |
| mod_end_o | output | 1 | One-cycle modulation end strobe |

## Verification
There are two places where two functions can act on the same clock edge. In the first, a slot edge is sampled on the very edge at which the last table entry takes effect and busy falls. The bench uses its own timing model to predict that edge and raises slot_clk so that it is sampled exactly there. It then expects no new run, followed by a normal start on the next edge. In the second, a last_bit_done pulse lands on the edge at which the modulation-end entry is still being fetched. The bench sends that pulse immediately after it sees mod_start_o, expects the pulse to be ignored, and checks that the timing is set by a second, later pulse. The model is compared on every clock throughout both cases.

// File: rtl/slot_tx_seq_pkg.sv
package slot_tx_seq_pkg;

  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] EV_NOP       = 4'h0;
  localparam logic [CODE_W-1:0] EV_CS_ON     = 4'h1;
  localparam logic [CODE_W-1:0] EV_CS_OFF    = 4'h2;
  localparam logic [CODE_W-1:0] EV_TXEN_HI   = 4'h3;
  localparam logic [CODE_W-1:0] EV_RAMP_UP   = 4'h4;
  localparam logic [CODE_W-1:0] EV_MOD_START = 4'h5;
  localparam logic [CODE_W-1:0] EV_MOD_END   = 4'h6;
  localparam logic [CODE_W-1:0] EV_RAMP_DN   = 4'h7;
  localparam logic [CODE_W-1:0] EV_TXEN_LO   = 4'h8;

  // strobe outputs, one per code; index order matches the top's pulse vector
  localparam int NUM_PULSE = 4;

  function automatic logic [CODE_W-1:0] pulse_code(input int unsigned i);
    case (i)
      0:       return EV_RAMP_UP;
      1:       return EV_RAMP_DN;
      2:       return EV_MOD_START;
      default: return EV_MOD_END;
    endcase
  endfunction

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_LOAD,
    ST_RUN,
    ST_WLB
  } seq_state_e;

endpackage

// File: rtl/slot_tx_seq_table.sv
module slot_tx_seq_table #(
  parameter int AW = 4,
  parameter int DW = 20
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // one write port, one registered read port: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/slot_tx_seq_trig.sv
module slot_tx_seq_trig (
  input  logic clk,
  input  logic rst,
  input  logic slot_clk,
  input  logic cfg_valid,
  input  logic busy,
  output logic start
);
  logic slot_q;

  always_ff @(posedge clk) begin
    if (rst) slot_q <= 1'b0;
    else     slot_q <= slot_clk;
  end

  // rising edge, accepted only when configured and idle
  assign start = slot_clk & ~slot_q & cfg_valid & ~busy;
endmodule

// File: rtl/slot_tx_seq_ctrl.sv
module slot_tx_seq_ctrl
  import slot_tx_seq_pkg::*;
#(
  parameter int N_EV          = 16,
  parameter int DLY_W         = 16,
  parameter int CLKS_PER_TICK = 8,
  parameter int MODEND_TICKS  = 30,
  parameter int AW            = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DLY_W-1:0]  init_dly,
  input  logic [CODE_W-1:0] rd_code,
  input  logic [DLY_W-1:0]  rd_dly,
  input  logic              last_bit_done,
  output logic [AW-1:0]     rd_addr,
  output logic              fire,
  output logic [CODE_W-1:0] fire_code,
  output logic              busy
);
  localparam longint MAX_CYC = ((longint'(1) << DLY_W) - 1 + MODEND_TICKS) * CLKS_PER_TICK;
  localparam int     CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] TAIL_CYC = CNT_W'(MODEND_TICKS * CLKS_PER_TICK);
  localparam logic [AW-1:0]    LAST_IDX = AW'(N_EV - 1);

  seq_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [AW-1:0]     idx;
  logic [CODE_W-1:0] code_q;
  logic [DLY_W-1:0]  dly_q;

  function automatic logic [CNT_W-1:0] to_cyc(input logic [DLY_W-1:0] d);
    return CNT_W'(d) * CNT_W'(CLKS_PER_TICK);
  endfunction

  always_comb begin
    fire      = (state == ST_RUN) && (cnt == '0);
    fire_code = code_q;
    if (start)     rd_addr = '0;
    else if (fire) rd_addr = idx + 1'b1;
    else           rd_addr = idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      idx    <= '0;
      code_q <= EV_NOP;
      dly_q  <= '0;
      busy   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_INIT;
            cnt   <= to_cyc(init_dly);
            idx   <= '0;
            busy  <= 1'b1;
          end
        end
        ST_INIT: begin
          if (cnt == '0) state <= ST_LOAD;
          else           cnt   <= cnt - 1'b1;
        end
        ST_LOAD: begin
          code_q <= rd_code;
          dly_q  <= rd_dly;
          if (rd_code == EV_MOD_END) begin
            state <= ST_WLB;
          end else begin
            cnt   <= to_cyc(rd_dly);
            state <= ST_RUN;
          end
        end
        ST_WLB: begin
          // re-anchor: count from the modulator's last bit
          if (last_bit_done) begin
            cnt   <= to_cyc(dly_q) + TAIL_CYC;
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (cnt == '0) begin
            if (idx == LAST_IDX) begin
              state <= ST_IDLE;
              busy  <= 1'b0;
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_LOAD;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slot_tx_seq_outs.sv
module slot_tx_seq_outs
  import slot_tx_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 init_txen,
  input  logic                 fire,
  input  logic [CODE_W-1:0]    fire_code,
  input  logic                 cs_en,
  output logic                 txen_o,
  output logic                 cs_win_o,
  output logic [NUM_PULSE-1:0] pulse_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      txen_o <= 1'b0;
    end else if (start) begin
      txen_o <= init_txen;
    end else if (fire) begin
      if (fire_code == EV_TXEN_HI)      txen_o <= 1'b1;
      else if (fire_code == EV_TXEN_LO) txen_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      cs_win_o <= 1'b0;
    end else if (fire && cs_en) begin
      if (fire_code == EV_CS_ON)       cs_win_o <= 1'b1;
      else if (fire_code == EV_CS_OFF) cs_win_o <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_PULSE; g++) begin : g_pulse
    logic q;
    always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= fire && (fire_code == pulse_code(g));
    end
    assign pulse_o[g] = q;
  end
endmodule

// File: rtl/slot_tx_seq.sv
module slot_tx_seq
  import slot_tx_seq_pkg::*;
#(
  parameter int N_EV          = 16,
  parameter int DLY_W         = 16,
  parameter int CLKS_PER_TICK = 8,
  parameter int MODEND_TICKS  = 30
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic                      cfg_hdr,
  input  logic [$clog2(N_EV)-1:0]   cfg_idx,
  input  logic [3:0]                cfg_code,
  input  logic [DLY_W-1:0]          cfg_dly,
  input  logic                      cfg_valid,
  input  logic                      slot_clk,
  input  logic                      cs_en,
  input  logic                      last_bit_done,
  output logic                      busy_o,
  output logic                      txen_o,
  output logic                      cs_win_o,
  output logic                      ramp_up_o,
  output logic                      ramp_dn_o,
  output logic                      mod_start_o,
  output logic                      mod_end_o
);
  localparam int AW = $clog2(N_EV);
  localparam int EW = CODE_W + DLY_W;

  logic [DLY_W-1:0]     init_dly_q;
  logic                 init_txen_q;
  logic [EW-1:0]        rd_entry;
  logic [AW-1:0]        rd_addr;
  logic                 start;
  logic                 fire;
  logic [CODE_W-1:0]    fire_code;
  logic [NUM_PULSE-1:0] pulses;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_dly_q  <= '0;
      init_txen_q <= 1'b0;
    end else if (cfg_we && cfg_hdr) begin
      init_dly_q  <= cfg_dly;
      init_txen_q <= cfg_code[0];
    end
  end

  slot_tx_seq_table #(.AW(AW), .DW(EW)) u_table (
    .clk   (clk),
    .we    (cfg_we & ~cfg_hdr),
    .waddr (cfg_idx),
    .wdata ({cfg_code, cfg_dly}),
    .raddr (rd_addr),
    .rdata (rd_entry)
  );

  slot_tx_seq_trig u_trig (
    .clk       (clk),
    .rst       (rst),
    .slot_clk  (slot_clk),
    .cfg_valid (cfg_valid),
    .busy      (busy_o),
    .start     (start)
  );

  slot_tx_seq_ctrl #(
    .N_EV          (N_EV),
    .DLY_W         (DLY_W),
    .CLKS_PER_TICK (CLKS_PER_TICK),
    .MODEND_TICKS  (MODEND_TICKS),
    .AW            (AW)
  ) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .init_dly      (init_dly_q),
    .rd_code       (rd_entry[EW-1:DLY_W]),
    .rd_dly        (rd_entry[DLY_W-1:0]),
    .last_bit_done (last_bit_done),
    .rd_addr       (rd_addr),
    .fire          (fire),
    .fire_code     (fire_code),
    .busy          (busy_o)
  );

  slot_tx_seq_outs u_outs (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .init_txen (init_txen_q),
    .fire      (fire),
    .fire_code (fire_code),
    .cs_en     (cs_en),
    .txen_o    (txen_o),
    .cs_win_o  (cs_win_o),
    .pulse_o   (pulses)
  );

  assign ramp_up_o   = pulses[0];
  assign ramp_dn_o   = pulses[1];
  assign mod_start_o = pulses[2];
  assign mod_end_o   = pulses[3];
endmodule

// File: rtl/slot_tx_seq_chk.sv
module slot_tx_seq_chk (
  input logic clk,
  input logic rst,
  input logic cfg_valid,
  input logic init_txen,
  input logic busy_o,
  input logic txen_o,
  input logic ramp_up_o,
  input logic ramp_dn_o,
  input logic mod_start_o,
  input logic mod_end_o
);
  assert_init_txen_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (txen_o == $past(init_txen)));

  assert_ramp_once_R3: assert property (@(posedge clk) disable iff (rst)
    ramp_up_o |=> !ramp_up_o);

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    $countones({ramp_up_o, ramp_dn_o, mod_start_o, mod_end_o}) <= 1);

  assert_cfg_gate_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(cfg_valid));

  assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !$past(busy_o)) |-> !(ramp_up_o || ramp_dn_o || mod_start_o || mod_end_o));

  assert_txen_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !$past(busy_o)) |-> $stable(txen_o));
endmodule

bind slot_tx_seq slot_tx_seq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_valid   (cfg_valid),
  .init_txen   (init_txen_q),
  .busy_o      (busy_o),
  .txen_o      (txen_o),
  .ramp_up_o   (ramp_up_o),
  .ramp_dn_o   (ramp_dn_o),
  .mod_start_o (mod_start_o),
  .mod_end_o   (mod_end_o)
);

// File: tb/slot_tx_seq_tb.sv
`timescale 1ns/1ps
module slot_tx_seq_tb;
  localparam int N   = 16;
  localparam int DW  = 16;
  localparam int CPT = 4;
  localparam int MT  = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          cfg_we = 0, cfg_hdr = 0, cfg_valid = 0;
  logic [3:0]    cfg_idx = '0;
  logic [3:0]    cfg_code = '0;
  logic [DW-1:0] cfg_dly = '0;
  logic          slot_clk = 0, cs_en = 0, last_bit_done = 0;
  logic busy_o, txen_o, cs_win_o, ramp_up_o, ramp_dn_o, mod_start_o, mod_end_o;

  slot_tx_seq #(.N_EV(N), .DLY_W(DW), .CLKS_PER_TICK(CPT), .MODEND_TICKS(MT)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_hdr(cfg_hdr), .cfg_idx(cfg_idx),
    .cfg_code(cfg_code), .cfg_dly(cfg_dly), .cfg_valid(cfg_valid), .slot_clk(slot_clk),
    .cs_en(cs_en), .last_bit_done(last_bit_done), .busy_o(busy_o), .txen_o(txen_o),
    .cs_win_o(cs_win_o), .ramp_up_o(ramp_up_o), .ramp_dn_o(ramp_dn_o),
    .mod_start_o(mod_start_o), .mod_end_o(mod_end_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string tag, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic chk_int(string tag, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model -----------------
  logic [3:0] tb_code [N];
  int         tb_dly  [N];
  int         tb_idly = 0;
  logic       tb_itxen = 0;

  int   cyc = 0;
  bit   m_busy, m_txen, m_cs, m_ru, m_rd, m_ms, m_me, m_slot_prev, m_wait;
  int   m_ev, m_next, m_lb_ok;

  // schedule entry m_ev after an anchor edge a (R2, R5)
  function automatic void plan(int a);
    if (tb_code[m_ev] == 4'h6) begin
      m_wait  = 1;
      m_lb_ok = a + 2;
      m_next  = -1;
    end else begin
      m_wait = 0;
      m_next = a + 2 + tb_dly[m_ev] * CPT;
    end
  endfunction

  function automatic void apply(logic [3:0] c);
    case (c)
      4'h3: m_txen = 1;
      4'h8: m_txen = 0;
      4'h4: m_ru = 1;
      4'h7: m_rd = 1;
      4'h5: m_ms = 1;
      4'h6: m_me = 1;
      4'h1: if (cs_en) m_cs = 1;
      4'h2: if (cs_en) m_cs = 0;
      default: ;  // dummies and unlisted codes (R6)
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_txen = 0; m_cs = 0; m_ru = 0; m_rd = 0; m_ms = 0; m_me = 0;
      m_slot_prev = 0; m_wait = 0; m_ev = 0; m_next = -1; m_lb_ok = 0;
    end else begin
      m_ru = 0; m_rd = 0; m_ms = 0; m_me = 0;
      if (!m_busy && slot_clk && !m_slot_prev && cfg_valid) begin
        m_busy = 1; m_txen = tb_itxen; m_cs = 0; m_ev = 0;
        plan(cyc + 1 + tb_idly * CPT);
      end else if (m_busy) begin
        if (m_wait) begin
          if (last_bit_done && cyc >= m_lb_ok) begin
            m_next = cyc + 1 + (tb_dly[m_ev] + MT) * CPT;
            m_wait = 0;
          end
        end else if (cyc == m_next) begin
          apply(tb_code[m_ev]);
          if (m_ev == N - 1) m_busy = 0;
          else begin
            m_ev++;
            plan(cyc);
          end
        end
      end
      m_slot_prev = slot_clk;
    end
    cyc++;
  end

  // ---------------- per-clock comparison -----------------
  int n_ru, n_me, n_cs;
  always @(negedge clk) begin
    if (!rst) begin
      chk("R1 R8", "busy_o", busy_o, m_busy);
      chk("R1 R3", "txen_o", txen_o, m_txen);
      chk("R4", "cs_win_o", cs_win_o, m_cs);
      chk("R2 R3", "ramp_up_o", ramp_up_o, m_ru);
      chk("R2 R3", "ramp_dn_o", ramp_dn_o, m_rd);
      chk("R2 R3", "mod_start_o", mod_start_o, m_ms);
      chk("R5 R10", "mod_end_o", mod_end_o, m_me);
      if (ramp_up_o) n_ru++;
      if (mod_end_o) n_me++;
      if (cs_win_o)  n_cs++;
    end
  end

  // ---------------- stimulus helpers -----------------
  task automatic wr_entry(int idx, logic [3:0] code, int dly);
    @(negedge clk);
    cfg_we = 1; cfg_hdr = 0; cfg_idx = 4'(idx); cfg_code = code; cfg_dly = DW'(dly);
    tb_code[idx] = code; tb_dly[idx] = dly;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wr_hdr(int dly, logic txen);
    @(negedge clk);
    cfg_we = 1; cfg_hdr = 1; cfg_code = {3'b000, txen}; cfg_dly = DW'(dly);
    tb_idly = dly; tb_itxen = txen;
    @(negedge clk);
    cfg_we = 0; cfg_hdr = 0;
  endtask

  task automatic slot_edge();
    @(negedge clk); slot_clk = 1;
    repeat (3) @(negedge clk);
    slot_clk = 0;
  endtask

  task automatic lb_pulse();
    @(negedge clk); last_bit_done = 1;
    @(negedge clk); last_bit_done = 0;
  endtask

  task automatic wait_mod_start();
    do @(negedge clk); while (!mod_start_o);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy_o);
  endtask

  // ---------------- main sequence -----------------
  initial begin
    repeat (4) @(negedge clk);
    // R9: reset state
    chk("R9", "busy_o in reset", busy_o, 0);
    chk("R9", "txen_o in reset", txen_o, 0);
    chk("R9", "strobes in reset", ramp_up_o | ramp_dn_o | mod_start_o | mod_end_o | cs_win_o, 0);
    rst = 0;

    // R7: trigger while unconfigured; R10: last-bit pulse while idle
    slot_edge();
    lb_pulse();
    chk("R7", "busy_o after unconfigured edge", busy_o, 0);
    chk("R10", "mod_end_o after idle last-bit", mod_end_o, 0);

    // run 1: full event set, carrier sense enabled
    wr_hdr(3, 1'b0);
    wr_entry(0, 4'h3, 1);
    wr_entry(1, 4'h1, 2);
    wr_entry(2, 4'h4, 0);
    wr_entry(3, 4'h2, 1);
    wr_entry(4, 4'h5, 2);
    wr_entry(5, 4'h6, 1);
    wr_entry(6, 4'h7, 2);
    wr_entry(7, 4'h8, 0);
    wr_entry(8, 4'hB, 1);
    for (int i = 9; i < N; i++) wr_entry(i, 4'h0, 0);
    cfg_valid = 1; cs_en = 1;
    n_ru = 0; n_me = 0; n_cs = 0;
    slot_edge();
    chk("R1", "busy_o after trigger", busy_o, 1);
    repeat (3) @(negedge clk);
    slot_edge();  // R7: ignored while running
    wait_mod_start();
    // R10: pulse lands while the modulation-end entry is still being fetched
    last_bit_done = 1;
    @(negedge clk); last_bit_done = 0;
    chk("R10", "mod_end_o after early pulse", mod_end_o, 0);
    repeat (20) @(negedge clk);
    lb_pulse();
    wait_idle();
    chk_int("R3", "ramp_up pulses in run 1", n_ru, 1);
    chk_int("R5", "mod_end pulses in run 1", n_me, 1);
    chk("R4", "cs window opened in run 1", n_cs > 0, 1);
    chk("R3", "txen_o low after run 1", txen_o, 0);

    // run 2: cs disabled, longer burst, unlisted codes as dummies
    wr_hdr(0, 1'b1);
    wr_entry(0, 4'h5, 0);
    wr_entry(1, 4'h6, 2);
    wr_entry(2, 4'h7, 1);
    wr_entry(3, 4'h1, 0);
    wr_entry(4, 4'h8, 1);
    wr_entry(5, 4'h2, 0);
    for (int i = 6; i < N; i++) wr_entry(i, 4'(9 + (i % 7)), i % 2);
    cs_en = 0; n_cs = 0; n_me = 0;
    slot_edge();
    chk("R1", "txen_o takes header level", txen_o, 1);
    wait_mod_start();
    repeat (40) @(negedge clk);
    last_bit_done = 1;
    begin
      int k = 0;
      do begin
        @(negedge clk); last_bit_done = 0; k++;
      end while (!mod_end_o);
      // R5: pulse sampled on edge p, strobe on edge p+1+(D+30)*T
      chk_int("R5", "last-bit to mod_end latency", k, 2 + (2 + MT) * CPT);
    end
    wait_idle();
    chk_int("R4", "cs window with cs_en low", n_cs, 0);
    chk("R6", "txen_o after dummies", txen_o, 0);

    // run 3: slot edge on the same edge as the final entry
    wr_entry(15, 4'h8, 3);
    cs_en = 1;
    slot_edge();
    wait_mod_start();
    repeat (5) @(negedge clk);
    lb_pulse();
    while (!(m_busy && m_ev == N - 1 && !m_wait && m_next == cyc)) @(negedge clk);
    slot_clk = 1;
    @(negedge clk);
    chk("R7", "edge on final-event cycle ignored", busy_o, 0);
    slot_clk = 0;
    @(negedge clk); slot_clk = 1;
    @(negedge clk);
    chk("R8", "new run after busy fell", busy_o, 1);
    repeat (2) @(negedge clk);
    slot_clk = 0;
    wait_mod_start();
    repeat (5) @(negedge clk);
    lb_pulse();
    wait_idle();
    chk("R8", "busy_o low at end", busy_o, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule